// File: doc/BRIEF.md
# Clock Root Selector with Half-Step Divider

This block is the root of one clock domain. It picks one of several free-running input clocks and divides that clock by a ratio set in half steps: 1, 1.5, 2, 2.5 and so on. Software programs it through a 32-bit register port that the bus clock runs. The port has a command word at byte offset 0x0 and a configuration word at byte offset 0x4.

A write to the configuration word lands only in a shadow copy and raises a pending flag. Software then sets the update request in the command word. The block lets the running output finish its current period and park low. It then swaps the selected input and the ratio, restarts the divider on the new clock, and clears the update request and the pending flag together once the new output is running. The output never shows a shortened high pulse during the swap. While the block is in reset or disabled, the output is parked low and a root-off status bit is set.

Top module: `hdiv_clock_root`

## Requirements
- R1: After reset both register words read 0 and the output runs from input 0 undivided: its period equals that input's period and it is high for one input half period.
- R2: The configuration word (offset 0x4) holds the ratio code in bits [4:0] and the input code in bits [10:8]. All other bits ignore writes and read 0. A read returns the last written (shadow) codes.
- R3: A configuration write sets the pending bit (bit 4 of the command word at offset 0x0). The output keeps its old input and ratio until a commit.
- R4: Writing 1 to command bit 0 starts a commit, and bit 0 reads 1 until the new settings drive the output. Bit 0 and bit 4 then clear in the same cycle. Writing 0 to bit 0, or writing any other command bit, has no effect.
- R5: For ratio code N the output period is the selected input period times max(N+1,2)/2, so codes 0 and 1 both divide by 1.
- R6: The output high phase lasts floor(max(N+1,2)/2) input half periods.
- R7: Input code k selects input k. A code at or above the number of inputs selects input 0.
- R8: During a commit every high pulse on the output is a complete high pulse of either the old or the new setting. Input and ratio change only while the divider is parked low.
- R9: While reset is asserted or the enable input is low, command bit 31 reads 1 and the output is held low after its current period ends. A commit requested in that state still completes.
- R10: A commit clears bit 0 within 1024 bus clock cycles when the old and new output periods are each under 64 bus cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock for the register port and commit control |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| en | input | 1 | Enable; low parks the output and sets root-off |
| src_clk | input | NSRC | Candidate input clocks |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte offset: 0x0 command, 0x4 configuration |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| clk_out | output | 1 | Divided root clock |

## Verification
The two functions that can fall in the same cycle are a commit in flight and the enable input dropping. A commit waits for the divider to park, while the disable also forces it to park and must not stall the handshake. The bench writes a new configuration, sets the update request, and pulls enable low two bus cycles later. It then requires the update and pending bits to clear within the bound, root-off to read 1, and the output to resume at the new ratio once enable returns. The same pairing is also provoked with enable already low before the request.

// File: rtl/hdiv_pkg.sv
`timescale 1ns/1ps
package hdiv_pkg;
    localparam int unsigned REG_W   = 32;
    localparam int unsigned ADDR_W  = 3;
    localparam logic [ADDR_W-1:0] OFS_CMD = 3'h0;
    localparam logic [ADDR_W-1:0] OFS_CFG = 3'h4;
    localparam int unsigned CMD_UPD_BIT   = 0;
    localparam int unsigned CMD_DIRTY_BIT = 4;
    localparam int unsigned CMD_OFF_BIT   = 31;
    localparam int unsigned DIV_LSB = 0;
    localparam int unsigned SRC_LSB = 8;

    typedef enum logic [1:0] {
        CM_RUN,
        CM_DRAIN,
        CM_SWAP,
        CM_LAUNCH
    } commit_e;

    // half periods of the selected input per output period
    function automatic int unsigned half_steps(input int unsigned code);
        return (code < 2) ? 2 : code + 1;
    endfunction

    // half periods for which the output stays high
    function automatic int unsigned high_steps(input int unsigned code);
        return half_steps(code) / 2;
    endfunction
endpackage

// File: rtl/hdiv_regs.sv
`timescale 1ns/1ps
module hdiv_regs
    import hdiv_pkg::*;
#(
    parameter int unsigned DIV_W = 5,
    parameter int unsigned SRC_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              root_off,
    input  logic              done,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              upd,
    output logic              dirty,
    output logic [DIV_W-1:0]  sh_div,
    output logic [SRC_W-1:0]  sh_src
);
    logic cmd_wr, cfg_wr;

    assign cmd_wr = bus_sel && bus_we && (bus_addr == OFS_CMD);
    assign cfg_wr = bus_sel && bus_we && (bus_addr == OFS_CFG);

    always_ff @(posedge clk) begin
        if (rst) begin
            upd    <= 1'b0;
            dirty  <= 1'b0;
            sh_div <= '0;
            sh_src <= '0;
        end else begin
            if (done) begin
                upd   <= 1'b0;
                dirty <= 1'b0;
            end
            // a write in the completion cycle wins over the clear
            if (cfg_wr) begin
                sh_div <= bus_wdata[DIV_LSB +: DIV_W];
                sh_src <= bus_wdata[SRC_LSB +: SRC_W];
                dirty  <= 1'b1;
            end
            if (cmd_wr && bus_wdata[CMD_UPD_BIT]) begin
                upd <= 1'b1;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_CMD) begin
            bus_rdata[CMD_UPD_BIT]   = upd;
            bus_rdata[CMD_DIRTY_BIT] = dirty;
            bus_rdata[CMD_OFF_BIT]   = root_off;
        end else if (bus_addr == OFS_CFG) begin
            bus_rdata[DIV_LSB +: DIV_W] = sh_div;
            bus_rdata[SRC_LSB +: SRC_W] = sh_src;
        end
    end
endmodule

// File: rtl/hdiv_commit.sv
`timescale 1ns/1ps
module hdiv_commit
    import hdiv_pkg::*;
#(
    parameter int unsigned DIV_W  = 5,
    parameter int unsigned SRC_W  = 3,
    parameter int unsigned SETTLE = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             root_off,
    input  logic             upd,
    input  logic [DIV_W-1:0] sh_div,
    input  logic [SRC_W-1:0] sh_src,
    input  logic             parked,
    output logic [DIV_W-1:0] act_div,
    output logic [SRC_W-1:0] act_src,
    output logic             halt,
    output logic             park_ack,
    output logic             done
);
    localparam int unsigned SC_W = $clog2(SETTLE + 1);

    commit_e         state;
    logic [1:0]      psync;
    logic [SC_W-1:0] settle_cnt;

    assign park_ack = psync[1];
    assign halt     = root_off || (state == CM_DRAIN) || (state == CM_SWAP);
    assign done     = (state == CM_LAUNCH) && (root_off || !park_ack);

    always_ff @(posedge clk) begin
        if (rst) begin
            psync      <= 2'b11;   // divider is parked while in reset
            state      <= CM_RUN;
            act_div    <= '0;
            act_src    <= '0;
            settle_cnt <= '0;
        end else begin
            psync <= {psync[0], parked};
            unique case (state)
                CM_RUN: begin
                    // wait until any earlier restart has been acknowledged
                    if (upd && (root_off || !park_ack)) state <= CM_DRAIN;
                end
                CM_DRAIN: begin
                    if (park_ack) begin
                        act_div    <= sh_div;
                        act_src    <= sh_src;
                        settle_cnt <= '0;
                        state      <= CM_SWAP;
                    end
                end
                CM_SWAP: begin
                    if (settle_cnt == SC_W'(SETTLE - 1)) state <= CM_LAUNCH;
                    else settle_cnt <= settle_cnt + 1'b1;
                end
                CM_LAUNCH: begin
                    if (done) state <= CM_RUN;
                end
                default: state <= CM_RUN;
            endcase
        end
    end
endmodule

// File: rtl/hdiv_divider.sv
`timescale 1ns/1ps
module hdiv_divider
    import hdiv_pkg::*;
#(
    parameter int unsigned NSRC  = 4,
    parameter int unsigned DIV_W = 5,
    parameter int unsigned SRC_W = 3
) (
    input  logic [NSRC-1:0]  src_clk,
    input  logic [DIV_W-1:0] act_div,
    input  logic [SRC_W-1:0] act_src,
    input  logic             halt,
    output logic             clk_out,
    output logic             parked
);
    localparam int unsigned CW    = DIV_W + 1;
    localparam int unsigned IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    typedef struct packed {
        logic          park;
        logic          lvl;
        logic [CW-1:0] cnt;
    } dstate_t;

    logic [IDX_W-1:0] sel;
    logic             mclk;
    logic [1:0]       hsync;
    logic             hold;
    logic [CW-1:0]    m_len, h_len;
    dstate_t          sp, sn, cur, nxt;

    always_comb begin
        if (32'(act_src) < NSRC) sel = act_src[IDX_W-1:0];
        else sel = '0;
        mclk  = src_clk[sel];
        m_len = CW'(half_steps(32'(act_div)));
        h_len = CW'(high_steps(32'(act_div)));
    end

    always_ff @(posedge mclk) hsync <= {hsync[0], halt};
    assign hold = hsync[1];

    // one half-period step per input edge; state split over two edge flops
    assign cur = dstate_t'(sp ^ sn);

    always_comb begin
        nxt = cur;
        if (cur.park) begin
            if (!hold) nxt = '{park: 1'b0, lvl: 1'b1, cnt: '0};
        end else if (cur.cnt >= m_len - 1'b1) begin
            nxt.cnt  = '0;
            nxt.park = hold;
            nxt.lvl  = !hold;
        end else begin
            nxt.cnt = cur.cnt + 1'b1;
            nxt.lvl = (cur.cnt + 1'b1) < h_len;
        end
    end

    always_ff @(posedge mclk) sp <= dstate_t'(nxt ^ sn);
    always_ff @(negedge mclk) sn <= dstate_t'(nxt ^ sp);

    assign clk_out = cur.lvl;
    assign parked  = cur.park;
endmodule

// File: rtl/hdiv_clock_root.sv
`timescale 1ns/1ps
module hdiv_clock_root
    import hdiv_pkg::*;
#(
    parameter int unsigned NSRC   = 4,
    parameter int unsigned DIV_W  = 5,
    parameter int unsigned SRC_W  = 3,
    parameter int unsigned SETTLE = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [NSRC-1:0]   src_clk,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [2:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              clk_out
);
    logic             root_off;
    logic             upd, dirty, done, halt, park_ack, parked;
    logic [DIV_W-1:0] sh_div, act_div;
    logic [SRC_W-1:0] sh_src, act_src;

    assign root_off = rst || !en;

    hdiv_regs #(.DIV_W(DIV_W), .SRC_W(SRC_W)) u_regs (
        .clk(clk), .rst(rst), .root_off(root_off), .done(done),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .upd(upd), .dirty(dirty), .sh_div(sh_div), .sh_src(sh_src)
    );

    hdiv_commit #(.DIV_W(DIV_W), .SRC_W(SRC_W), .SETTLE(SETTLE)) u_commit (
        .clk(clk), .rst(rst), .root_off(root_off), .upd(upd),
        .sh_div(sh_div), .sh_src(sh_src), .parked(parked),
        .act_div(act_div), .act_src(act_src), .halt(halt),
        .park_ack(park_ack), .done(done)
    );

    hdiv_divider #(.NSRC(NSRC), .DIV_W(DIV_W), .SRC_W(SRC_W)) u_div (
        .src_clk(src_clk), .act_div(act_div), .act_src(act_src),
        .halt(halt), .clk_out(clk_out), .parked(parked)
    );
endmodule

// File: rtl/hdiv_clock_root_chk.sv
`timescale 1ns/1ps
module hdiv_clock_root_chk #(
    parameter int unsigned DIV_W = 5,
    parameter int unsigned SRC_W = 3,
    parameter int unsigned LIMIT = 1024
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             bus_sel,
    input logic             bus_we,
    input logic [2:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic             upd,
    input logic             dirty,
    input logic             halt,
    input logic             park_ack,
    input logic [DIV_W-1:0] act_div,
    input logic [SRC_W-1:0] act_src
);
    localparam logic [31:0] FIELD_MASK =
        ((32'd1 << DIV_W) - 32'd1) | (((32'd1 << SRC_W) - 32'd1) << 8);
    localparam int unsigned BW = $clog2(LIMIT + 1);

    logic          cmd_wr, cfg_wr;
    logic [BW-1:0] busy_cnt;

    assign cmd_wr = bus_sel && bus_we && (bus_addr == 3'h0);
    assign cfg_wr = bus_sel && bus_we && (bus_addr == 3'h4);

    always_ff @(posedge clk) begin
        if (rst || !upd) busy_cnt <= '0;
        else if (busy_cnt != BW'(LIMIT)) busy_cnt <= busy_cnt + 1'b1;
    end

    // R2
    cfg_fields_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && bus_addr == 3'h4) |-> ((bus_rdata & ~FIELD_MASK) == 32'd0));

    // R9
    off_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && bus_addr == 3'h0) |-> (bus_rdata[31] == !en));

    // R4
    upd_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(upd) |-> $past(cmd_wr && bus_wdata[0]));

    // R4
    upd_fall_dirty_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(upd) |-> (!dirty || $past(cfg_wr)));

    // R3
    act_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable({act_div, act_src}) |-> $past(upd));

    // R8
    act_swap_parked_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable({act_div, act_src}) |-> ($past(halt) && $past(park_ack)));

    // R10
    upd_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy_cnt < BW'(LIMIT));
endmodule

bind hdiv_clock_root hdiv_clock_root_chk #(.DIV_W(DIV_W), .SRC_W(SRC_W)) u_chk (.*);

// File: tb/sim_hdiv_clock_root.sv
`timescale 1ns/1ps
module sim_hdiv_clock_root;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b1;
    logic [3:0]  src_clk = 4'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        clk_out;

    int n_chk = 0, n_fail = 0;
    longint cyc = 0;
    localparam longint WD = 190000;
    localparam int POLL_MAX = 400;

    // src code, ratio code, expected period ns, expected high ns
    // input half periods: 5, 6, 10, 3 ns
    localparam int unsigned VEC [8][4] = '{
        '{1, 0, 12, 6}, '{0, 1, 10, 5}, '{0, 2, 15, 5}, '{2, 4, 50, 20},
        '{3, 7, 24, 12}, '{1, 31, 192, 96}, '{5, 3, 20, 10}, '{2, 5, 60, 30}
    };

    hdiv_clock_root u0 (
        .clk(clk), .rst(rst), .en(en), .src_clk(src_clk),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_out(clk_out)
    );

    always #4 clk = ~clk;
    always #5 src_clk[0] = ~src_clk[0];
    always #6 src_clk[1] = ~src_clk[1];
    always #10 src_clk[2] = ~src_clk[2];
    always #3 src_clk[3] = ~src_clk[3];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD) begin
            chk(1'b0, "watchdog", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // switchover pulse monitor
    realtime rise_t = 0.0, mon_start = 0.0;
    bit      mon_on = 1'b0;
    longint  mon_a = 0, mon_b = 0;
    always @(posedge clk_out) rise_t = $realtime;
    always @(negedge clk_out) begin
        if (mon_on && rise_t >= mon_start) begin
            longint w;
            w = longint'($rtoi($realtime - rise_t + 0.5));
            chk(w == mon_a || w == mon_b, "R8 high pulse during commit", w, mon_b);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic poll(output int n);
        logic [31:0] d;
        n = POLL_MAX;
        for (int i = 0; i < POLL_MAX; i++) begin
            rd(3'h0, d);
            if (!d[0]) begin n = i; break; end
        end
    endtask

    task automatic meas(output longint per, output longint hi);
        realtime t0, t1, t2;
        repeat (3) @(posedge clk_out);
        t0 = $realtime;
        @(negedge clk_out); t1 = $realtime;
        @(posedge clk_out); t2 = $realtime;
        per = longint'($rtoi(t2 - t0 + 0.5));
        hi  = longint'($rtoi(t1 - t0 + 0.5));
    endtask

    task automatic count_high(input int cycles, output int highs);
        highs = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (clk_out) highs++;
        end
    endtask

    initial begin
        logic [31:0] d;
        longint per, hi, prev_hi;
        int n, highs;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (20) @(negedge clk);

        // R1 reset state
        rd(3'h0, d); chk(d == 32'h0, "R1 command after reset", d, 0);
        rd(3'h4, d); chk(d == 32'h0, "R1 config after reset", d, 0);
        meas(per, hi);
        chk(per == 10, "R1 reset period", per, 10);
        chk(hi == 5, "R1 reset high", hi, 5);

        // R2 field layout, R3 pending without effect
        wr(3'h4, 32'hFFFF_FFFF);
        rd(3'h4, d); chk(d == 32'h0000_071F, "R2 config read", d, 32'h71F);
        rd(3'h0, d); chk(d == 32'h0000_0010, "R3 pending set", d, 32'h10);
        meas(per, hi);
        chk(per == 10, "R3 output unchanged", per, 10);

        // R4 writes without bit 0 do nothing
        wr(3'h0, 32'hFFFF_FFFE);
        repeat (20) @(negedge clk);
        rd(3'h0, d); chk(d == 32'h0000_0010, "R4 no-op command write", d, 32'h10);

        // table of settings
        prev_hi = 5;
        for (int i = 0; i < 8; i++) begin
            wr(3'h4, (VEC[i][0] << 8) | VEC[i][1]);
            rd(3'h0, d); chk(d[4] == 1'b1, "R3 pending after write", d, 32'h10);
            mon_a = prev_hi; mon_b = VEC[i][3];
            mon_start = $realtime; mon_on = 1'b1;
            wr(3'h0, 32'h1);
            poll(n);
            chk(n < POLL_MAX, "R10 commit bound", n, POLL_MAX);
            rd(3'h0, d); chk(d == 32'h0, "R4 update and pending clear", d, 0);
            meas(per, hi);
            chk(per == VEC[i][2], "R5/R7 period", per, VEC[i][2]);
            chk(hi == VEC[i][3], "R6 high time", hi, VEC[i][3]);
            mon_on = 1'b0;
            prev_hi = VEC[i][3];
        end

        // R9 disabled: root-off, output low, commit still completes
        en = 1'b0;
        repeat (50) @(negedge clk);
        rd(3'h0, d); chk(d == 32'h8000_0000, "R9 root-off bit", d, 32'h8000_0000);
        count_high(100, highs); chk(highs == 0, "R9 output low", highs, 0);
        wr(3'h4, (3 << 8) | 2);
        wr(3'h0, 32'h1);
        poll(n); chk(n < POLL_MAX, "R9 commit while off", n, POLL_MAX);
        rd(3'h0, d); chk(d == 32'h8000_0000, "R9 status after commit", d, 32'h8000_0000);
        count_high(50, highs); chk(highs == 0, "R9 output still low", highs, 0);
        en = 1'b1;
        meas(per, hi);
        chk(per == 9, "R9 period after enable", per, 9);
        chk(hi == 3, "R6 high after enable", hi, 3);

        // R9 disable arriving during a commit
        wr(3'h4, (0 << 8) | 3);
        wr(3'h0, 32'h1);
        repeat (2) @(negedge clk);
        en = 1'b0;
        poll(n); chk(n < POLL_MAX, "R9 commit with disable", n, POLL_MAX);
        rd(3'h0, d); chk(d == 32'h8000_0000, "R9 status after overlap", d, 32'h8000_0000);
        en = 1'b1;
        meas(per, hi);
        chk(per == 20, "R9 period after overlap", per, 20);

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd(3'h4, d); chk(d == 32'h0, "R1 config after rerun reset", d, 0);
        rd(3'h0, d); chk(d == 32'h0, "R1 command after rerun reset", d, 0);
        meas(per, hi);
        chk(per == 10, "R1 period after rerun reset", per, 10);
        chk(hi == 5, "R1 high after rerun reset", hi, 5);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule